// File: doc/BRIEF.md
# UART Transmit and Receive Holding Queues

This block holds the bytes that pass between a host and a UART's serial shifters. The host writes bytes to the tail of a transmit queue; the transmit shifter takes them from the head. The receive shifter appends each completed byte to the tail of a receive queue; the host takes them from the head. Both heads are visible on the data outputs with no read latency.

A two-bit mode input selects the usable depth of both queues: a single-byte holding register, a 16-entry FIFO or a 128-entry FIFO. All three modes use the same 128-entry storage. The block reports, for each queue, a fill level and empty and full flags. It also reports when the transmitter is idle and when a received byte was lost because the receive queue was full. Changing the mode empties both queues.

Top module: `uart_hold_fifos`

## Requirements
- R1: After reset both levels are 0, both empty flags are 1, both full flags are 0, `rx_overrun_o` is 0, and `tx_idle_o` is 1 while `tx_shift_busy_i` is 0.
- R2: The depth is set by `mode_i`: 0 gives 1 entry, 1 gives 16 entries, and 2 or 3 give 128 entries. A full flag is 1 exactly when that queue holds the selected depth.
- R3: A host write while the transmit queue is full is discarded. The level stays the same and the stored bytes are unchanged.
- R4: Each queue returns bytes in the order they were written. `tx_data_o` and `host_rdata_o` show the head entry in the same cycle, and each accepted pop or read advances the head at the next clock edge.
- R5: A pop or read of an empty queue changes no state. While a queue is empty, its data output reads 0.
- R6: A receive push while the receive queue is full is dropped, the stored bytes are kept, and `rx_overrun_o` is 1 from the next cycle.
- R7: `rx_overrun_o` stays 1 until a cycle with `status_rd_i` high and reads 0 after that cycle. If a new overrun occurs in the same cycle as the status read, the flag stays 1.
- R8: `tx_idle_o` is 1 exactly when the transmit queue is empty and `tx_shift_busy_i` is 0.
- R9: The level outputs are 7 bits wide and equal the entry count, capped at 127. A full 128-entry queue therefore reads 127 with its full flag set.
- R10: A change of `mode_i` empties both queues: from the next cycle both levels are 0. The change does not clear `rx_overrun_o`.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full are both accepted, and the level stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Depth mode: 0 single byte, 1 sixteen, 2 or 3 one hundred twenty-eight |
| host_wr_i | input | 1 | Host write strobe to the transmit queue |
| host_wdata_i | input | 8 | Host write byte |
| tx_pop_i | input | 1 | Transmit shifter takes the head byte |
| tx_data_o | output | 8 | Head of transmit queue (0 when empty) |
| tx_shift_busy_i | input | 1 | Transmit shift register still sending a character |
| rx_push_i | input | 1 | Receive shifter delivers a completed byte |
| rx_data_i | input | 8 | Received byte |
| host_rd_i | input | 1 | Host read strobe from the receive queue |
| host_rdata_o | output | 8 | Head of receive queue (0 when empty) |
| status_rd_i | input | 1 | Host status read; clears the overrun flag |
| tx_level_o | output | 7 | Transmit fill level |
| rx_level_o | output | 7 | Receive fill level |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_full_o | output | 1 | Receive queue full |
| tx_idle_o | output | 1 | Transmit queue empty and shifter finished |
| rx_overrun_o | output | 1 | A received byte was lost to a full queue |

## Verification
The bench fills and drains both queues in every mode, one entry past the depth. A design with a wrong depth limit or a late full flag would show the wrong level, take the extra byte, or return data out of order. It checks the capped level at 128 entries, where a design that truncates the count would read 0 while full. It also checks a pop from an empty queue, a push and pop in the same cycle, and an overrun that occurs in the same cycle as a status read, which a design giving the clear priority would lose. Finally, a mode change made with data present must leave both queues empty while keeping the overrun flag.

// File: rtl/uart_hq_pkg.sv
package uart_hq_pkg;
    localparam int HQ_DATA_W    = 8;
    localparam int HQ_DEPTH_MAX = 128;
    localparam int HQ_DEPTH_MID = 16;
    localparam int HQ_PTR_W     = $clog2(HQ_DEPTH_MAX);
    localparam int HQ_CNT_W     = HQ_PTR_W + 1;
    localparam int HQ_LVL_W     = 7;

    typedef enum logic [1:0] {
        HQ_BYTE   = 2'd0,
        HQ_D16    = 2'd1,
        HQ_D128   = 2'd2,
        HQ_D128_R = 2'd3
    } hq_mode_e;

    typedef struct packed {
        logic [HQ_CNT_W-1:0] count;
        logic                empty;
        logic                full;
    } hq_stat_t;

    function automatic logic [HQ_CNT_W-1:0] hq_limit(input hq_mode_e m);
        case (m)
            HQ_BYTE: hq_limit = HQ_CNT_W'(1);
            HQ_D16:  hq_limit = HQ_CNT_W'(HQ_DEPTH_MID);
            default: hq_limit = HQ_CNT_W'(HQ_DEPTH_MAX);
        endcase
    endfunction

    function automatic logic [HQ_LVL_W-1:0] hq_level(input logic [HQ_CNT_W-1:0] c);
        localparam int LMAX = (1 << HQ_LVL_W) - 1;
        if (int'(c) > LMAX) hq_level = HQ_LVL_W'(LMAX);
        else                hq_level = HQ_LVL_W'(c);
    endfunction
endpackage

// File: rtl/uart_hq_mode.sv
module uart_hq_mode
    import uart_hq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_i,
    output logic                flush_o,
    output logic [HQ_CNT_W-1:0] limit_o
);
    hq_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= hq_mode_e'(mode_i);
        else     mode_q <= hq_mode_e'(mode_i);
    end

    assign flush_o = (hq_mode_e'(mode_i) != mode_q) && !rst;
    assign limit_o = hq_limit(mode_q);

    // R2
    limit_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (limit_o == HQ_CNT_W'(1)) || (limit_o == HQ_CNT_W'(HQ_DEPTH_MID)) ||
        (limit_o == HQ_CNT_W'(HQ_DEPTH_MAX)));
endmodule

// File: rtl/uart_hq_store.sv
module uart_hq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/uart_hq_queue.sv
module uart_hq_queue
    import uart_hq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic [HQ_CNT_W-1:0]  limit,
    input  logic                 push,
    input  logic [HQ_DATA_W-1:0] push_data,
    input  logic                 pop,
    output logic [HQ_DATA_W-1:0] head_data,
    output hq_stat_t             stat,
    output logic                 push_drop
);
    logic [HQ_PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [HQ_CNT_W-1:0]  count;
    logic                 empty, full, push_ok, pop_ok;
    logic [HQ_DATA_W-1:0] raw;

    assign empty     = (count == '0);
    assign full      = (count >= limit);
    assign push_ok   = push && !full && !flush;
    assign pop_ok    = pop && !empty && !flush;
    assign push_drop = push && full && !flush;

    uart_hq_store #(.DATA_W(HQ_DATA_W), .DEPTH(HQ_DEPTH_MAX)) store_i (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wr_ptr),
        .wdata (push_data),
        .raddr (rd_ptr),
        .rdata (raw)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_data   = empty ? '0 : raw;
    assign stat.count  = count;
    assign stat.empty  = empty;
    assign stat.full   = full;

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= limit);
    // R3
    drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> $stable(count));
    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> (count == '0));
    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));
    // R11
    both_level_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty && !full && !flush) |=> $stable(count));
endmodule

// File: rtl/uart_hold_fifos.sv
module uart_hold_fifos
    import uart_hq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           mode_i,
    input  logic                 host_wr_i,
    input  logic [HQ_DATA_W-1:0] host_wdata_i,
    input  logic                 tx_pop_i,
    output logic [HQ_DATA_W-1:0] tx_data_o,
    input  logic                 tx_shift_busy_i,
    input  logic                 rx_push_i,
    input  logic [HQ_DATA_W-1:0] rx_data_i,
    input  logic                 host_rd_i,
    output logic [HQ_DATA_W-1:0] host_rdata_o,
    input  logic                 status_rd_i,
    output logic [HQ_LVL_W-1:0]  tx_level_o,
    output logic [HQ_LVL_W-1:0]  rx_level_o,
    output logic                 tx_empty_o,
    output logic                 tx_full_o,
    output logic                 rx_empty_o,
    output logic                 rx_full_o,
    output logic                 tx_idle_o,
    output logic                 rx_overrun_o
);
    logic                flush;
    logic [HQ_CNT_W-1:0] limit;
    hq_stat_t            tx_st, rx_st;
    logic                tx_drop_unused, rx_drop, ovr_q;

    uart_hq_mode mode_i_u (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode_i),
        .flush_o (flush),
        .limit_o (limit)
    );

    uart_hq_queue txq_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .limit     (limit),
        .push      (host_wr_i),
        .push_data (host_wdata_i),
        .pop       (tx_pop_i),
        .head_data (tx_data_o),
        .stat      (tx_st),
        .push_drop (tx_drop_unused)
    );

    uart_hq_queue rxq_i (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .limit     (limit),
        .push      (rx_push_i),
        .push_data (rx_data_i),
        .pop       (host_rd_i),
        .head_data (host_rdata_o),
        .stat      (rx_st),
        .push_drop (rx_drop)
    );

    always_ff @(posedge clk) begin
        if (rst)              ovr_q <= 1'b0;
        else if (rx_drop)     ovr_q <= 1'b1;
        else if (status_rd_i) ovr_q <= 1'b0;
    end

    assign rx_overrun_o = ovr_q;
    assign tx_level_o   = hq_level(tx_st.count);
    assign rx_level_o   = hq_level(rx_st.count);
    assign tx_empty_o   = tx_st.empty;
    assign tx_full_o    = tx_st.full;
    assign rx_empty_o   = rx_st.empty;
    assign rx_full_o    = rx_st.full;
    assign tx_idle_o    = tx_st.empty && !tx_shift_busy_i;

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_push_i && rx_full_o && !flush) |=> rx_overrun_o);
    // R7
    overrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun_o && !status_rd_i) |=> rx_overrun_o);
    // R7
    overrun_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (status_rd_i && !(rx_push_i && rx_full_o && !flush)) |=> !rx_overrun_o);
    // R8
    idle_busy_chk: assert property (@(posedge clk) disable iff (rst)
        tx_shift_busy_i |-> !tx_idle_o);
endmodule

// File: tb/uart_hold_fifos_tb_top.sv
module uart_hold_fifos_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic host_wr = 0, tx_pop = 0, busy = 0, rx_push = 0, host_rd = 0, st_rd = 0;
    logic [7:0] wdata = 0, rxd = 0;
    logic [7:0] tx_data, rdata;
    logic [6:0] tx_lvl, rx_lvl;
    logic tx_empty, tx_full, rx_empty, rx_full, tx_idle, ovr;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_hold_fifos dut_i (
        .clk(clk), .rst(rst), .mode_i(mode),
        .host_wr_i(host_wr), .host_wdata_i(wdata), .tx_pop_i(tx_pop),
        .tx_data_o(tx_data), .tx_shift_busy_i(busy),
        .rx_push_i(rx_push), .rx_data_i(rxd), .host_rd_i(host_rd),
        .host_rdata_o(rdata), .status_rd_i(st_rd),
        .tx_level_o(tx_lvl), .rx_level_o(rx_lvl),
        .tx_empty_o(tx_empty), .tx_full_o(tx_full),
        .rx_empty_o(rx_empty), .rx_full_o(rx_full),
        .tx_idle_o(tx_idle), .rx_overrun_o(ovr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    function automatic int dep(input int m);
        return (m == 0) ? 1 : (m == 1) ? 16 : 128;
    endfunction
    function automatic int lvl(input int n);
        return (n > 127) ? 127 : n;
    endfunction
    function automatic logic [7:0] txp(input int i, input int m);
        return 8'((i * 7 + 3) ^ (m * 40));
    endfunction
    function automatic logic [7:0] rxp(input int i, input int m);
        return 8'((i * 13 + 5) ^ (m * 17));
    endfunction

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        eq("R1 tx_level", tx_lvl, 0);
        eq("R1 rx_level", rx_lvl, 0);
        eq("R1 tx_empty", tx_empty, 1);
        eq("R1 rx_empty", rx_empty, 1);
        eq("R1 tx_full", tx_full, 0);
        eq("R1 rx_full", rx_full, 0);
        eq("R1 overrun", ovr, 0);
        eq("R1 idle", tx_idle, 1);

        for (int m = 0; m < 4; m++) begin
            int d;
            d = dep(m);
            mode = 2'(m);
            cyc(); cyc();
            // Transmit fill one past depth: R2 R3 R9
            for (int i = 0; i <= d; i++) begin
                host_wr = 1; wdata = txp(i, m);
                cyc();
                host_wr = 0;
                eq("R2 tx_full", tx_full, (i + 1 >= d) ? 1 : 0);
                eq("R9 tx_level", tx_lvl, lvl((i + 1 > d) ? d : i + 1));
                eq("R8 idle busy-free nonempty", tx_idle, 0);
            end
            // Drain: R4 R3 (extra byte not stored)
            for (int i = 0; i < d; i++) begin
                eq("R4 tx order", tx_data, txp(i, m));
                tx_pop = 1; cyc(); tx_pop = 0;
            end
            eq("R3 tx empty after depth pops", tx_empty, 1);
            eq("R5 tx data zero when empty", tx_data, 0);
            tx_pop = 1; cyc(); tx_pop = 0;
            eq("R5 tx pop on empty", tx_lvl, 0);
            eq("R8 idle", tx_idle, 1);

            // Receive fill one past depth: R6
            for (int i = 0; i <= d; i++) begin
                rx_push = 1; rxd = rxp(i, m);
                cyc();
                rx_push = 0;
                eq("R2 rx_full", rx_full, (i + 1 >= d) ? 1 : 0);
                eq("R9 rx_level", rx_lvl, lvl((i + 1 > d) ? d : i + 1));
                eq("R6 overrun", ovr, (i == d) ? 1 : 0);
            end
            cyc();
            eq("R7 overrun holds", ovr, 1);
            st_rd = 1; cyc(); st_rd = 0;
            eq("R7 overrun cleared", ovr, 0);
            for (int i = 0; i < d; i++) begin
                eq("R6 rx contents kept / R4 order", rdata, rxp(i, m));
                host_rd = 1; cyc(); host_rd = 0;
            end
            eq("R5 rx empty", rx_empty, 1);
            eq("R5 rx data zero", rdata, 0);
            host_rd = 1; cyc(); host_rd = 0;
            eq("R5 rx read on empty", rx_lvl, 0);
        end

        // R8 idle vs busy
        busy = 1; cyc();
        eq("R8 idle busy", tx_idle, 0);
        busy = 0; cyc();
        eq("R8 idle free", tx_idle, 1);

        // R11 simultaneous push/pop in 16 mode
        mode = 2'd1; cyc(); cyc();
        for (int i = 0; i < 3; i++) begin
            host_wr = 1; wdata = 8'(100 + i); cyc();
        end
        host_wr = 1; wdata = 8'd103; tx_pop = 1; cyc();
        host_wr = 0; tx_pop = 0;
        eq("R11 level same", tx_lvl, 3);
        for (int i = 1; i < 4; i++) begin
            eq("R11 order", tx_data, 100 + i);
            tx_pop = 1; cyc(); tx_pop = 0;
        end

        // R7 set wins over status read
        mode = 2'd0; cyc(); cyc();
        rx_push = 1; rxd = 8'h55; cyc();
        st_rd = 1; cyc();
        rx_push = 0; st_rd = 0;
        eq("R7 set wins", ovr, 1);

        // R10 mode change flushes, keeps overrun
        mode = 2'd1; cyc();
        eq("R10 rx level", rx_lvl, 0);
        for (int i = 0; i < 5; i++) begin
            host_wr = 1; wdata = 8'(i); rx_push = 1; rxd = 8'(i); cyc();
        end
        host_wr = 0; rx_push = 0;
        eq("R10 tx level before", tx_lvl, 5);
        mode = 2'd2; cyc();
        eq("R10 tx flushed", tx_lvl, 0);
        eq("R10 rx flushed", rx_lvl, 0);
        eq("R10 tx empty", tx_empty, 1);
        eq("R10 overrun kept", ovr, 1);

        done = 1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 150000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule